// File: doc/BRIEF.md
# Remote DMA Port Engine

This block connects a host-visible data port to a byte-wide local packet memory. Software loads a 16-bit remote pointer and a 16-bit remote byte count, issues a remote-read or remote-write command, and then moves data through the data port. Each host access moves one unit of 1, 2 or 4 bytes, stored little-endian. The engine then advances the pointer and shrinks the count by the unit size. When the pointer lands on the end of the receive ring, it jumps back to the ring's first page. When the count runs out, a transfer-complete status bit is raised.

The block also holds the interrupt status and mask registers and drives a level interrupt line. An access whose base address lies outside both valid memory windows does not touch memory. A read of such an address returns all-ones bytes. Pointer and count still advance as usual.

Internally a three-state machine runs each access. S_IDLE waits for `dp_go` and takes the S_IDLE→S_BEAT transition. S_BEAT issues one memory byte per cycle and moves on (S_BEAT→S_SETTLE) after the last byte. S_SETTLE collects the final read byte and commits pointer, count and status. It then returns with S_SETTLE→S_IDLE.

Register offsets, all 8 bits wide:

| Offset | Register |
|---|---|
| 0 | command |
| 1 | ring first page |
| 2 | ring last page (exclusive) |
| 3 | pointer low byte |
| 4 | pointer high byte |
| 5 | count low byte |
| 6 | count high byte |
| 7 | status |
| 8 | mask |
| 9 | config |

Offsets 10 to 15 read zero.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset, status reads 0x80, mask, pointer and count read 0, and `irq` is low.
- R2: With config bit 0 clear, each data-port access moves one byte at the pointer, adds 1 to the pointer and subtracts 1 from the count.
- R3: With config bit 0 set, an access moves 2 bytes from the pointer with bit 0 cleared. The lower address byte sits in `dp_rdata[7:0]`/`dp_wdata[7:0]`. Pointer advances by 2 from its unaligned value and count drops by 2.
- R4: An access with `dp_long` high moves 4 little-endian bytes from the pointer with bit 0 cleared. Pointer advances by 4 and count drops by 4.
- R5: If the advanced pointer equals ring last page × 256, it is replaced by ring first page × 256.
- R6: If the count before an access is less than or equal to the unit size, the count becomes 0 and status bit 6 (transfer complete) is set.
- R7: A command write with bit 0 (halt) clear, with bit 3 (remote read) or bit 4 (remote write) set, and a count of 0 sets status bit 6 at once. With halt set, it does not.
- R8: A command write with bit 0 clear clears status bit 7. A command write with bit 0 set leaves it unchanged.
- R9: Writing 1 to status bit 6 clears it. Bit 7 is never cleared by a status write.
- R10: `irq` is high exactly when (status AND mask AND 0x7F) is nonzero; status bit 7 never raises it.
- R11: Valid base addresses are 0x0000–0x001F and 0x4000–0xBFFF. Otherwise no memory cycle is issued, and read bytes return 0xFF. Pointer and count still update.
- R12: After `dp_go` is sampled in idle, `dp_busy` is high for unit-size + 1 cycles. `dp_done` then pulses for one cycle with `dp_rdata` valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| dp_go | input | 1 | Start one data-port access (taken when idle) |
| dp_we | input | 1 | Access is a write |
| dp_long | input | 1 | Access is 4 bytes wide |
| dp_wdata | input | 32 | Data-port write data, little-endian |
| dp_rdata | output | 32 | Data-port read data, valid with dp_done |
| dp_busy | output | 1 | Access in progress |
| dp_done | output | 1 | One-cycle completion pulse |
| mem_en | output | 1 | Memory byte cycle request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after request |
| irq | output | 1 | Interrupt request |

## Verification
Several states are hard to reach from the ports. One is a pointer that sits just below the ring end when a multi-byte access is issued, so the wrap follows an advance of 2 or 4. Another is a count smaller than the unit size. The stimulus programs the ring limits and the pointer directly to those values before each access. Unaligned word reads, zero-count starts with and without halt, and accesses on both sides of each window edge are also driven on purpose. A behavioural model predicts memory contents, pointer, count and interrupt level, and the interrupt is compared every clock.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
    localparam int PTR_W    = 16;
    localparam int CNT_W    = 16;
    localparam int DP_W     = 32;
    localparam int DP_BYTES = DP_W / 8;
    localparam int BEAT_W   = $clog2(DP_BYTES);
    localparam int SIZE_W   = BEAT_W + 1;

    localparam logic [3:0] RA_CMD    = 4'd0;
    localparam logic [3:0] RA_FIRST  = 4'd1;
    localparam logic [3:0] RA_LAST   = 4'd2;
    localparam logic [3:0] RA_PTR_LO = 4'd3;
    localparam logic [3:0] RA_PTR_HI = 4'd4;
    localparam logic [3:0] RA_CNT_LO = 4'd5;
    localparam logic [3:0] RA_CNT_HI = 4'd6;
    localparam logic [3:0] RA_STATUS = 4'd7;
    localparam logic [3:0] RA_MASK   = 4'd8;
    localparam logic [3:0] RA_CFG    = 4'd9;

    localparam int CMD_HALT   = 0;
    localparam int CMD_RREAD  = 3;
    localparam int CMD_RWRITE = 4;

    localparam int ST_XFER_DONE = 6;
    localparam int ST_RESET     = 7;
    localparam logic [7:0] IRQ_ELIGIBLE = 8'h7F;

    typedef enum logic [1:0] {
        S_IDLE,
        S_BEAT,
        S_SETTLE
    } beat_state_e;
endpackage

// File: rtl/rdma_window.sv
module rdma_window #(
    parameter int ADDR_W   = 16,
    parameter int LOW_END  = 32,
    parameter int HIGH_BEG = 16384,
    parameter int HIGH_END = 49152
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              ok
);
    logic [31:0] a32;

    always_comb begin
        a32 = 32'(addr);
        ok  = (a32 < 32'(LOW_END)) ||
              ((a32 >= 32'(HIGH_BEG)) && (a32 < 32'(HIGH_END)));
    end
endmodule

// File: rtl/rdma_ctl_regs.sv
module rdma_ctl_regs
    import rdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              cmt_valid,
    input  logic [SIZE_W-1:0] cmt_size,
    output logic [PTR_W-1:0]  cur_ptr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              word_mode,
    output logic              stat_reset,
    output logic              irq
);
    logic [7:0]       cmd_q, first_q, last_q, mask_q, cfg_q;
    logic [PTR_W-1:0] ptr_q, ptr_sum, ptr_adv;
    logic [CNT_W-1:0] cnt_q, cnt_adv;
    logic             done_q, rst_bit_q;
    logic             cnt_last, run_cmd, zero_start, done_set, done_clr;
    logic [7:0]       status_v;

    // Pointer/count advance with ring wrap
    always_comb begin
        ptr_sum  = ptr_q + PTR_W'(cmt_size);
        ptr_adv  = (ptr_sum == {last_q, 8'h00}) ? {first_q, 8'h00} : ptr_sum;
        cnt_last = (cnt_q <= CNT_W'(cmt_size));
        cnt_adv  = cnt_last ? '0 : (cnt_q - CNT_W'(cmt_size));
    end

    always_comb begin
        run_cmd    = reg_wr && (reg_addr == RA_CMD) && !reg_wdata[CMD_HALT];
        zero_start = run_cmd && (reg_wdata[CMD_RREAD] || reg_wdata[CMD_RWRITE]) &&
                     (cnt_q == '0);
        done_set   = (cmt_valid && cnt_last) || zero_start;
        done_clr   = reg_wr && (reg_addr == RA_STATUS) && reg_wdata[ST_XFER_DONE];
        status_v   = {rst_bit_q, done_q, 6'b0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= 8'h01;
            first_q   <= '0;
            last_q    <= '0;
            mask_q    <= '0;
            cfg_q     <= '0;
            ptr_q     <= '0;
            cnt_q     <= '0;
            done_q    <= 1'b0;
            rst_bit_q <= 1'b1;
        end else begin
            // set wins over a same-cycle clear
            if (done_set)      done_q <= 1'b1;
            else if (done_clr) done_q <= 1'b0;
            if (run_cmd) rst_bit_q <= 1'b0;

            // host byte writes take priority over an engine commit
            if (reg_wr && reg_addr == RA_PTR_LO)      ptr_q[7:0]  <= reg_wdata;
            else if (reg_wr && reg_addr == RA_PTR_HI) ptr_q[15:8] <= reg_wdata;
            else if (cmt_valid)                       ptr_q       <= ptr_adv;

            if (reg_wr && reg_addr == RA_CNT_LO)      cnt_q[7:0]  <= reg_wdata;
            else if (reg_wr && reg_addr == RA_CNT_HI) cnt_q[15:8] <= reg_wdata;
            else if (cmt_valid)                       cnt_q       <= cnt_adv;

            if (reg_wr) begin
                case (reg_addr)
                    RA_CMD:   cmd_q   <= reg_wdata;
                    RA_FIRST: first_q <= reg_wdata;
                    RA_LAST:  last_q  <= reg_wdata;
                    RA_MASK:  mask_q  <= reg_wdata;
                    RA_CFG:   cfg_q   <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CMD:    reg_rdata = cmd_q;
            RA_FIRST:  reg_rdata = first_q;
            RA_LAST:   reg_rdata = last_q;
            RA_PTR_LO: reg_rdata = ptr_q[7:0];
            RA_PTR_HI: reg_rdata = ptr_q[15:8];
            RA_CNT_LO: reg_rdata = cnt_q[7:0];
            RA_CNT_HI: reg_rdata = cnt_q[15:8];
            RA_STATUS: reg_rdata = status_v;
            RA_MASK:   reg_rdata = mask_q;
            RA_CFG:    reg_rdata = cfg_q;
            default:   reg_rdata = 8'h00;
        endcase
    end

    assign cur_ptr    = ptr_q;
    assign cur_cnt    = cnt_q;
    assign word_mode  = cfg_q[0];
    assign stat_reset = rst_bit_q;
    assign irq        = |(status_v & mask_q & IRQ_ELIGIBLE);
endmodule

// File: rtl/rdma_beat_fsm.sv
module rdma_beat_fsm
    import rdma_pkg::*;
#(
    parameter int LOW_END  = 32,
    parameter int HIGH_BEG = 16384,
    parameter int HIGH_END = 49152
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dp_go,
    input  logic              dp_we,
    input  logic              dp_long,
    input  logic [DP_W-1:0]   dp_wdata,
    output logic [DP_W-1:0]   dp_rdata,
    output logic              dp_busy,
    output logic              dp_done,
    input  logic [PTR_W-1:0]  cur_ptr,
    input  logic              word_mode,
    output logic              cmt_valid,
    output logic [SIZE_W-1:0] cmt_size,
    output logic              mem_en,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    beat_state_e       state_q, state_d;
    logic [BEAT_W-1:0] beat_q, pend_idx_q;
    logic [SIZE_W-1:0] size_q, go_size;
    logic [PTR_W-1:0]  base_q, go_base;
    logic              ok_q, we_q, pend_q, done_q, go_ok;
    logic [DP_W-1:0]   wbuf_q, rbuf_q;
    logic              last_beat;

    always_comb begin
        go_size = dp_long ? SIZE_W'(4) : (word_mode ? SIZE_W'(2) : SIZE_W'(1));
        go_base = (dp_long || word_mode) ? {cur_ptr[PTR_W-1:1], 1'b0} : cur_ptr;
    end

    rdma_window #(
        .ADDR_W  (PTR_W),
        .LOW_END (LOW_END),
        .HIGH_BEG(HIGH_BEG),
        .HIGH_END(HIGH_END)
    ) u_win (
        .addr(go_base),
        .ok  (go_ok)
    );

    assign last_beat = ({1'b0, beat_q} == (size_q - SIZE_W'(1)));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (dp_go) state_d = S_BEAT;
            S_BEAT:   if (last_beat) state_d = S_SETTLE;
            S_SETTLE: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q     <= '0;
            size_q     <= SIZE_W'(1);
            base_q     <= '0;
            ok_q       <= 1'b0;
            we_q       <= 1'b0;
            wbuf_q     <= '0;
            rbuf_q     <= '0;
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
            done_q     <= 1'b0;
        end else begin
            pend_q     <= (state_q == S_BEAT) && !we_q && ok_q;
            pend_idx_q <= beat_q;
            done_q     <= (state_q == S_SETTLE);
            if (state_q == S_IDLE && dp_go) begin
                size_q <= go_size;
                base_q <= go_base;
                ok_q   <= go_ok;
                we_q   <= dp_we;
                wbuf_q <= dp_wdata;
                beat_q <= '0;
                for (int k = 0; k < DP_BYTES; k++) begin
                    rbuf_q[k*8 +: 8] <= ((k < 32'(go_size)) && !go_ok) ? 8'hFF : 8'h00;
                end
            end else begin
                if (state_q == S_BEAT) beat_q <= beat_q + BEAT_W'(1);
                if (pend_q) rbuf_q[{pend_idx_q, 3'b000} +: 8] <= mem_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        mem_en    = (state_q == S_BEAT) && ok_q;
        mem_we    = we_q;
        mem_addr  = base_q + PTR_W'(beat_q);
        mem_wdata = wbuf_q[{beat_q, 3'b000} +: 8];
        dp_busy   = (state_q != S_IDLE);
        dp_done   = done_q;
        dp_rdata  = rbuf_q;
        cmt_valid = (state_q == S_SETTLE);
        cmt_size  = size_q;
    end
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
    import rdma_pkg::*;
#(
    parameter int LOW_END  = 32,
    parameter int HIGH_BEG = 16384,
    parameter int HIGH_END = 49152
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        dp_go,
    input  logic        dp_we,
    input  logic        dp_long,
    input  logic [31:0] dp_wdata,
    output logic [31:0] dp_rdata,
    output logic        dp_busy,
    output logic        dp_done,
    output logic        mem_en,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        irq
);
    logic              cmt_valid;
    logic [SIZE_W-1:0] cmt_size;
    logic [PTR_W-1:0]  cur_ptr;
    logic [CNT_W-1:0]  cur_cnt;
    logic              word_mode;
    logic              stat_reset;

    rdma_ctl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cmt_valid (cmt_valid),
        .cmt_size  (cmt_size),
        .cur_ptr   (cur_ptr),
        .cur_cnt   (cur_cnt),
        .word_mode (word_mode),
        .stat_reset(stat_reset),
        .irq       (irq)
    );

    rdma_beat_fsm #(
        .LOW_END (LOW_END),
        .HIGH_BEG(HIGH_BEG),
        .HIGH_END(HIGH_END)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .dp_go    (dp_go),
        .dp_we    (dp_we),
        .dp_long  (dp_long),
        .dp_wdata (dp_wdata),
        .dp_rdata (dp_rdata),
        .dp_busy  (dp_busy),
        .dp_done  (dp_done),
        .cur_ptr  (cur_ptr),
        .word_mode(word_mode),
        .cmt_valid(cmt_valid),
        .cmt_size (cmt_size),
        .mem_en   (mem_en),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );
endmodule

// File: rtl/rdma_port_engine_chk.sv
module rdma_port_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [3:0]  reg_addr,
    input logic        dp_go,
    input logic        dp_busy,
    input logic        dp_done,
    input logic        mem_en,
    input logic [15:0] cur_cnt,
    input logic        stat_reset
);
    p_reset_bit_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_reset |=> !stat_reset);

    p_reset_bit_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'd7 && stat_reset) |=> stat_reset);

    p_cnt_no_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> (cur_cnt <= $past(cur_cnt)));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dp_done |=> !dp_done);

    p_go_starts_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!dp_busy && dp_go) |=> dp_busy);

    p_mem_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !dp_busy |-> !mem_en);
endmodule

bind rdma_port_engine rdma_port_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .dp_go     (dp_go),
    .dp_busy   (dp_busy),
    .dp_done   (dp_done),
    .mem_en    (mem_en),
    .cur_cnt   (cur_cnt),
    .stat_reset(stat_reset)
);

// File: tb/rdma_port_engine_tb_top.sv
`timescale 1ns/1ps
module rdma_port_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        dp_go = 1'b0, dp_we = 1'b0, dp_long = 1'b0;
    logic [31:0] dp_wdata = '0;
    logic [31:0] dp_rdata;
    logic        dp_busy, dp_done, mem_en, mem_we, irq;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int n_chk = 0, n_err = 0, n_mem = 0;
    bit started = 0, ended = 0;

    logic [7:0] phys [int];
    logic [7:0] exp_mem [int];

    // behavioural model state
    int m_ptr = 0, m_cnt = 0, m_first = 0, m_last = 0, m_mask = 0, m_cfg = 0;
    bit m_done = 0, m_rst = 1;

    always #2.5 clk = ~clk;

    rdma_port_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_go(dp_go), .dp_we(dp_we),
        .dp_long(dp_long), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata), .dp_busy(dp_busy),
        .dp_done(dp_done), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
    );

    // byte memory with one-cycle read latency
    always @(posedge clk) begin
        if (mem_en) begin
            n_mem++;
            if (mem_we) phys[int'(mem_addr)] = mem_wdata;
            else mem_rdata <= phys.exists(int'(mem_addr)) ? phys[int'(mem_addr)] : 8'h00;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit m_irq();
        return m_done && m_mask[6];
    endfunction

    // R10: interrupt level compared every clock
    always @(posedge clk) begin
        if (started && rst_n) chk(irq == m_irq(), "R10 irq level", irq, m_irq());
    end

    function automatic bit win_ok(input int a);
        return (a < 32) || (a >= 16384 && a < 49152);
    endfunction

    function automatic logic [7:0] em(input int a);
        return exp_mem.exists(a) ? exp_mem[a] : 8'h00;
    endfunction

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        case (a)
            4'd0: if (!d[0]) begin
                      m_rst = 0;
                      if ((d[3] || d[4]) && m_cnt == 0) m_done = 1;
                  end
            4'd1: m_first = d;
            4'd2: m_last = d;
            4'd3: m_ptr = (m_ptr & 32'hFF00) | d;
            4'd4: m_ptr = (m_ptr & 32'h00FF) | (int'(d) << 8);
            4'd5: m_cnt = (m_cnt & 32'hFF00) | d;
            4'd6: m_cnt = (m_cnt & 32'h00FF) | (int'(d) << 8);
            4'd7: if (d[6]) m_done = 0;
            4'd8: m_mask = d;
            4'd9: m_cfg = d;
            default: ;
        endcase
    endtask

    task automatic chk_reg(input logic [3:0] a, input int exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp[7:0], tag, reg_rdata, exp[7:0]);
    endtask

    task automatic set_ptr(input int p);
        wr_reg(4'd3, p[7:0]); wr_reg(4'd4, p[15:8]);
    endtask

    task automatic set_cnt(input int c);
        wr_reg(4'd5, c[7:0]); wr_reg(4'd6, c[15:8]);
    endtask

    task automatic chk_ptr_cnt(input string tag);
        chk_reg(4'd3, m_ptr & 255, {tag, " ptr lo"});
        chk_reg(4'd4, (m_ptr >> 8) & 255, {tag, " ptr hi"});
        chk_reg(4'd5, m_cnt & 255, {tag, " cnt lo"});
        chk_reg(4'd6, (m_cnt >> 8) & 255, {tag, " cnt hi"});
    endtask

    task automatic dp_access(input bit we, input bit lng, input logic [31:0] wd, input string tag);
        int size, base, nb, mem0;
        bit ok, seen;
        logic [31:0] er;
        size = lng ? 4 : (m_cfg[0] ? 2 : 1);
        base = (lng || m_cfg[0]) ? (m_ptr & 32'hFFFE) : m_ptr;
        ok = win_ok(base);
        er = '0;
        for (int k = 0; k < size; k++) er[k*8 +: 8] = ok ? em((base + k) & 32'hFFFF) : 8'hFF;
        @(negedge clk);
        dp_go = 1'b1; dp_we = we; dp_long = lng; dp_wdata = wd;
        mem0 = n_mem; nb = 0; seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (i == 0) dp_go = 1'b0;
            if (dp_done) begin seen = 1; break; end
            if (dp_busy) nb++;
        end
        chk(seen, {tag, " R12 done seen"}, seen, 1);
        chk(nb == size + 1, {tag, " R12 busy cycles"}, nb, size + 1);
        chk(n_mem - mem0 == (ok ? size : 0), {tag, " R11 mem cycles"}, n_mem - mem0, ok ? size : 0);
        if (!we) chk(dp_rdata == er, {tag, " read data"}, dp_rdata, er);
        if (we && ok) for (int k = 0; k < size; k++) exp_mem[(base + k) & 32'hFFFF] = wd[k*8 +: 8];
        m_ptr = (m_ptr + size) & 32'hFFFF;
        if (m_ptr == m_last * 256) m_ptr = m_first * 256;
        if (m_cnt <= size) begin m_cnt = 0; m_done = 1; end
        else m_cnt = m_cnt - size;
        @(negedge clk);
        chk(!dp_done, {tag, " R12 done one cycle"}, dp_done, 0);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #500000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        started = 1;
        // R1 reset state
        chk_reg(4'd7, 8'h80, "R1 status");
        chk_reg(4'd8, 8'h00, "R1 mask");
        chk_ptr_cnt("R1");
        chk(irq == 1'b0, "R1 irq", irq, 0);
        // R10 bit 7 never drives irq, R9 bit 7 not write-clearable
        wr_reg(4'd8, 8'hFF);
        chk(irq == 1'b0, "R10 reset bit masked", irq, 0);
        wr_reg(4'd7, 8'hFF);
        chk_reg(4'd7, 8'h80, "R9 reset bit kept");
        // R8
        wr_reg(4'd0, 8'h01);
        chk_reg(4'd7, 8'h80, "R8 halt keeps reset bit");
        wr_reg(4'd0, 8'h20);
        chk_reg(4'd7, 8'h00, "R8 run clears reset bit");
        wr_reg(4'd8, 8'h40);
        // ring and byte writes (R2)
        wr_reg(4'd1, 8'h40); wr_reg(4'd2, 8'h48); wr_reg(4'd9, 8'h00);
        set_ptr(16'h4000); set_cnt(6);
        wr_reg(4'd0, 8'h12);
        dp_access(1, 0, 32'hA1, "R2 b0");
        dp_access(1, 0, 32'hB2, "R2 b1");
        dp_access(1, 0, 32'hC3, "R2 b2");
        dp_access(1, 0, 32'hD4, "R2 b3");
        chk_ptr_cnt("R2");
        // R3 word write, R6 count exhausted
        wr_reg(4'd9, 8'h01);
        dp_access(1, 0, 32'h6655, "R3 word wr");
        chk_ptr_cnt("R6");
        chk_reg(4'd7, 8'h40, "R6 done bit");
        chk(irq == 1'b1, "R10 irq on done", irq, 1);
        wr_reg(4'd7, 8'h40);
        chk_reg(4'd7, 8'h00, "R9 done cleared");
        // R4 long read
        set_ptr(16'h4000); set_cnt(8); wr_reg(4'd0, 8'h0A);
        dp_access(0, 1, 0, "R4 long rd");
        chk_ptr_cnt("R4");
        // R3 unaligned word read
        set_ptr(16'h4005);
        dp_access(0, 0, 0, "R3 unaligned rd");
        chk_ptr_cnt("R3");
        // R5 wrap after word and long
        set_ptr(16'h47FE); set_cnt(100);
        dp_access(1, 0, 32'h1234, "R5 word wr");
        chk_ptr_cnt("R5 word");
        set_ptr(16'h47FC);
        dp_access(1, 1, 32'h89ABCDEF, "R5 long wr");
        chk_ptr_cnt("R5 long");
        set_ptr(16'h47FC);
        dp_access(0, 1, 0, "R5 long rd");
        chk_ptr_cnt("R5 rd");
        // R6 count smaller than unit
        set_ptr(16'h4100); set_cnt(1);
        dp_access(1, 0, 32'h7788, "R6 short cnt");
        chk_ptr_cnt("R6 short");
        chk_reg(4'd7, 8'h40, "R6 short done");
        wr_reg(4'd7, 8'h40);
        // R7 zero-count start
        wr_reg(4'd0, 8'h0B);
        chk_reg(4'd7, 8'h00, "R7 halted start");
        wr_reg(4'd0, 8'h0A);
        chk_reg(4'd7, 8'h40, "R7 zero start");
        wr_reg(4'd7, 8'h40);
        // R11 windows
        wr_reg(4'd9, 8'h00);
        set_ptr(16'h1000); set_cnt(16);
        dp_access(1, 0, 32'h55, "R11 out wr");
        chk_ptr_cnt("R11 out");
        dp_access(0, 1, 0, "R11 out long rd");
        chk_ptr_cnt("R11 out rd");
        set_ptr(16'h0010);
        dp_access(1, 0, 32'h5A, "R11 low wr");
        set_ptr(16'h0010);
        dp_access(0, 0, 0, "R11 low rd");
        set_ptr(16'hBFFF);
        dp_access(1, 0, 32'h3C, "R11 top in");
        dp_access(1, 0, 32'h3D, "R11 top out");
        chk_ptr_cnt("R11 edge");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule